// File: doc/BRIEF.md
# Modulated Phase Accumulator NCO

This block is the phase engine of a direct digital synthesizer. Every clock it adds a tuning increment to a wide phase accumulator. The increment is a center frequency word plus an offset frequency word, and a gating input can drop the offset word. Switching that input back and forth moves the output between two frequencies, which is how binary frequency-shift keying is done. A two-bit quadrant select adds a fixed quarter-turn phase step, and a run control can hold the accumulator feedback at zero. Releasing the run control on two units at the same edge starts them in step, with their relative phase set only by their quadrant selects.

The output is the upper part of the modulated phase, ready to address a sine lookup. All control inputs pass through one aligned delay line. As a result, a change on any control input reaches the output after the same fixed number of clocks.

Top module: `nco_quad_fsk`

## Requirements
- R1: While `rst_n` is low, the accumulator and every pipeline register are cleared, and `phase_out` reads 0.
- R2: While `acc_run` is high, the accumulator grows each clock by `center_word + offset_word`, modulo 2^ACC_W, when `offset_en` is high.
- R3: While `offset_en` is low, `offset_word` has no effect, and the increment is `center_word` alone.
- R4: `quad_sel` adds a quarter-turn phase step to the output: 00 adds 0, 01 adds 0x4000, 10 adds 0x8000 and 11 adds 0xC000, modulo 2^16 (the top two output bits carry the quadrant).
- R5: While `acc_run` is low, the accumulator feedback is zero, so the accumulator holds only the latest increment. With a zero increment, `phase_out` equals the quadrant step alone.
- R6: A value on any control input, sampled at rising edge m, first affects `phase_out` just after rising edge m+LATENCY-1. With the default LATENCY of 14, this is the 14th edge counting edge m as the first.
- R7: `phase_out` is the top OUT_W bits of the accumulated phase plus the quadrant step, and wraps modulo 2^OUT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| center_word | input | ACC_W | Center frequency word |
| offset_word | input | ACC_W | Offset frequency word |
| offset_en | input | 1 | High adds the offset word to the increment |
| quad_sel | input | 2 | Quadrant phase step select |
| acc_run | input | 1 | Low forces the accumulator feedback to zero |
| phase_out | output | OUT_W | Modulated phase, upper bits |

## Verification
The bench builds the block with its defaults: a 48-bit accumulator, a 16-bit output and a latency of 14. This keeps the full-width wrap of the accumulator in reach with center words near 2^48. It also makes the 14-cycle latency of an offset-enable toggle measurable edge by edge. A behavioural model built on a queue tracks every clock. It covers run release from the cleared state, all four quadrant codes, and reset applied again in the middle of a run.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int QUAD_W = 2;
    typedef logic [QUAD_W-1:0] quad_t;
endpackage

// File: rtl/nco_ctrl_delay.sv
module nco_ctrl_delay
    import nco_pkg::*;
#(
    parameter int ACC_W = 48,
    parameter int DEPTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] center_i,
    input  logic [ACC_W-1:0] offset_i,
    input  logic             offset_en_i,
    input  quad_t            quad_i,
    input  logic             acc_run_i,
    output logic [ACC_W-1:0] inc_o,
    output logic             run_o,
    output quad_t            quad_o
);
    localparam int LAST = DEPTH - 1;

    typedef struct packed {
        logic [ACC_W-1:0] inc;
        logic             run;
        quad_t            quad;
    } stage_t;

    stage_t stg_d [DEPTH];
    stage_t stg_q [DEPTH];

    always_comb begin
        stg_d[0].inc  = center_i + (offset_en_i ? offset_i : '0);
        stg_d[0].run  = acc_run_i;
        stg_d[0].quad = quad_i;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign inc_o  = stg_q[LAST].inc;
    assign run_o  = stg_q[LAST].run;
    assign quad_o = stg_q[LAST].quad;

    // R3: a gated-off offset leaves the center word as the increment
    a_r3_offset_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !offset_en_i |=> stg_q[0].inc == $past(center_i));

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_shift_chk
            // R6: every control field advances one stage per clock
            a_r6_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> stg_q[g] == $past(stg_q[g-1]));
        end
    endgenerate
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int ACC_W = 48,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_i,
    input  logic             run_i,
    input  quad_t            quad_i,
    output logic [OUT_W-1:0] acc_top_o,
    output quad_t            quad_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        quad_t            quad;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d.acc  = (run_i ? st_q.acc : '0) + inc_i;
        st_d.quad = quad_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_top_o = st_q.acc[ACC_W-1 -: OUT_W];
    assign quad_o    = st_q.quad;

    // R2: running accumulator advances by the increment
    a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> st_q.acc == $past(st_q.acc) + $past(inc_i));

    // R5: halted feedback leaves only the last increment
    a_r5_feedback_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> st_q.acc == $past(inc_i));
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out
    import nco_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] acc_top_i,
    input  quad_t            quad_i,
    output logic [OUT_W-1:0] phase_o
);
    localparam int LOW_W = OUT_W - QUAD_W;

    logic [OUT_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = acc_top_i + {quad_i, {LOW_W{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;

    // R4: output differs from the accumulated phase only by the quadrant step
    a_r4_quadrant_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_q - $past(acc_top_i)) == {$past(quad_i), {LOW_W{1'b0}}});
endmodule

// File: rtl/nco_quad_fsk.sv
module nco_quad_fsk
    import nco_pkg::*;
#(
    parameter int ACC_W   = 48,
    parameter int OUT_W   = 16,
    parameter int LATENCY = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] center_word,
    input  logic [ACC_W-1:0] offset_word,
    input  logic             offset_en,
    input  logic [1:0]       quad_sel,
    input  logic             acc_run,
    output logic [OUT_W-1:0] phase_out
);
    localparam int DLY_DEPTH = LATENCY - 2;

    logic [ACC_W-1:0] inc_dly;
    logic             run_dly;
    quad_t            quad_dly;
    logic [OUT_W-1:0] acc_top;
    quad_t            quad_acc;

    nco_ctrl_delay #(.ACC_W(ACC_W), .DEPTH(DLY_DEPTH)) u_ctrl_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .center_i   (center_word),
        .offset_i   (offset_word),
        .offset_en_i(offset_en),
        .quad_i     (quad_sel),
        .acc_run_i  (acc_run),
        .inc_o      (inc_dly),
        .run_o      (run_dly),
        .quad_o     (quad_dly)
    );

    nco_phase_acc #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_phase_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (inc_dly),
        .run_i    (run_dly),
        .quad_i   (quad_dly),
        .acc_top_o(acc_top),
        .quad_o   (quad_acc)
    );

    nco_phase_out #(.OUT_W(OUT_W)) u_phase_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_top_i(acc_top),
        .quad_i   (quad_acc),
        .phase_o  (phase_out)
    );
endmodule

// File: tb/test_nco_quad_fsk.sv
module test_nco_quad_fsk;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 14;
    localparam int DQ         = LAT - 2;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [47:0] center_word = '0;
    logic [47:0] offset_word = '0;
    logic        offset_en = 1'b0;
    logic [1:0]  quad_sel = 2'b00;
    logic        acc_run = 1'b0;
    logic [15:0] phase_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    cmp_en   = 1'b0;

    nco_quad_fsk i_nco_quad_fsk (
        .clk        (clk),
        .rst_n      (rst_n),
        .center_word(center_word),
        .offset_word(offset_word),
        .offset_en  (offset_en),
        .quad_sel   (quad_sel),
        .acc_run    (acc_run),
        .phase_out  (phase_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: a queue of pending controls, an accumulator and an output
    logic [50:0] mq[$];
    logic [50:0] m_head;
    logic [47:0] m_acc;
    logic [1:0]  m_quad;
    logic [15:0] m_p;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.delete();
            for (int i = 0; i < DQ; i++) mq.push_back('0);
            m_acc  = '0;
            m_quad = '0;
            m_p    = '0;
        end else begin
            m_head = mq.pop_front();
            m_p    = m_acc[47:32] + {m_quad, 14'b0};
            m_acc  = (m_head[2] ? m_acc : 48'd0) + m_head[50:3];
            m_quad = m_head[1:0];
            mq.push_back({center_word + (offset_en ? offset_word : 48'd0), acc_run, quad_sel});
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: phase_out=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) check(cur_req, phase_out, m_p);
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        cycles(3);
        check("R1", phase_out, 16'h0000);
        cmp_en = 1'b1;
        rst_n  = 1'b1;

        // R2: running accumulation with the offset enabled
        cur_req = "R2";
        center_word = 48'h0123_4567_89AB;
        offset_word = 48'h0010_0000_0001;
        offset_en = 1'b1;
        acc_run = 1'b1;
        cycles(60);

        // R7: increment near full scale, so the output wraps
        cur_req = "R7";
        center_word = 48'hFFFF_0000_0000;
        offset_en = 1'b0;
        cycles(40);
        center_word = 48'h3FFF_FFFF_FFFF;
        cycles(40);

        // R3: offset gated off; the offset word must not matter
        cur_req = "R3";
        acc_run = 1'b0;
        center_word = 48'h2222_0000_0000;
        offset_word = 48'h5555_0000_0000;
        offset_en = 1'b0;
        cycles(20);
        check("R3", phase_out, 16'h2222);
        offset_word = 48'h7777_0000_0000;
        cycles(20);
        check("R3", phase_out, 16'h2222);
        offset_en = 1'b1;
        cycles(20);
        check("R2", phase_out, 16'h9999);

        // R6: latency of an offset-enable toggle
        cur_req = "R6";
        center_word = '0;
        offset_word = 48'h1234_0000_0000;
        offset_en = 1'b0;
        cycles(20);
        check("R6", phase_out, 16'h0000);
        offset_en = 1'b1;
        begin
            int k;
            k = 0;
            for (int i = 1; i <= 30; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (phase_out == 16'h1234) begin
                    k = i;
                    break;
                end
            end
            n_checks++;
            if (k != LAT) begin
                n_fail++;
                $display("FAIL R6: latency=%0d expected %0d", k, LAT);
            end
        end
        cycles(10);

        // R4: all four quadrant codes on a fixed phase
        cur_req = "R4";
        offset_en = 1'b0;
        center_word = 48'h0100_0000_0000;
        for (int q = 0; q < 4; q++) begin
            quad_sel = q[1:0];
            cycles(18);
            check("R4", phase_out, 16'h0100 + 16'(q * 16'h4000));
        end

        // R5: hold feedback at zero with zero increment -> quadrant step only
        cur_req = "R5";
        center_word = '0;
        quad_sel = 2'b10;
        acc_run = 1'b1;
        cycles(30);
        acc_run = 1'b0;
        cycles(20);
        check("R5", phase_out, 16'h8000);
        center_word = 48'h0001_0000_0000;
        acc_run = 1'b1;
        cycles(30);
        acc_run = 1'b0;
        cycles(6);
        acc_run = 1'b1;
        cycles(30);

        // R1: reset in the middle of a run
        cur_req = "R1";
        cmp_en = 1'b0;
        rst_n = 1'b0;
        cycles(2);
        check("R1", phase_out, 16'h0000);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        cycles(12);
        check("R1", phase_out, 16'h0000);
        cycles(30);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < WD_CYCLES; i++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule